// File: doc/BRIEF.md
# Fractional UART Baud-Rate Generator

This block produces the 16x oversampling strobe for a 16550-style serial port from one reference clock. The rate is set in three stages in series: a coded integer prescaler that divides the reference, a fractional X/Y rate multiplier built as a phase accumulator, and a 16-bit divisor counter. A sample strobe is produced each time the divisor counter wraps. Every sixteenth sample strobe is also marked as a bit-rate strobe. All strobes are clock enables in the reference clock domain.

Software sets the rate through a small register file of 32-bit words with word-indexed addresses. The two divisor bytes can only be written while the divisor-access bit of the line-control word is set. Any write that changes the rate restarts every counter, so a new setting begins from a known phase. A fractional word with X not below Y is refused and leaves the old setting in place.

Top module: `uart_baud_gen`

## Requirements
- R1: After reset the registers read back: index 0 = 1, index 1 = 0, index 3 = 0, index 10 = 4, index 11 = 0x0000FDE8 (X = 0, Y = 65000). No sample or bit strobe occurs until a non-zero X is written.
- R2: Prescaler code (index 10, bits 2:0) selects the reference divide ratio. Codes 0,1,2,3,4,5,6,7 give 1,2,4,8,10,12,16,20.
- R3: The mean sample-strobe period in reference cycles is P × D × Y / X, where P is the prescale ratio and D is the divisor. X sits in bits 31:16 and Y in bits 15:0 of index 11. Over 1000 strobes the total stays within 2P+2 cycles of this value.
- R4: A write to index 11 with X ≥ Y is ignored. The stored word keeps its previous value and the counters are not restarted.
- R5: The divisor low byte (index 0, bits 7:0) and high byte (index 1, bits 7:0) change only when bit 7 of the line-control word (index 3, bits 7:0) is set. Otherwise the write has no effect.
- R6: A divisor value of 0 behaves as a divisor of 1.
- R7: The bit strobe fires together with every sixteenth sample strobe, counted from a restart, and never on two consecutive cycles.
- R8: An accepted write to index 0, 1, 10 or 11 clears the prescaler, accumulator, divisor and oversample counters, and suppresses strobes in the following cycle. With P = 1, X = 1, Y = 2 and D = 1, the first sample strobe is visible after the third clock edge following the write edge.
- R9: Index 0, 1, 3, 10 and 11 read back the stored values. Other indices read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Word index for read and write |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| sample_tick_o | output | 1 | 16x oversampling strobe |
| bit_tick_o | output | 1 | Bit-rate strobe, every 16th sample strobe |

## Verification
The bench builds the block with its defaults: a 16-bit divisor and 16-bit X and Y fields. This gives the nominal setting of Y = 65000 with a divisor of 1, so 9600, 115200 and 460800 baud can be reached with prescale ratios 10, 10 and 2. Small X/Y pairs such as 1/2 make the strobe pattern fully periodic. With those pairs the prescaler codes, the zero divisor, the restart latency and the sixteen-to-one bit strobe can all be checked to the exact cycle.

// File: rtl/ubg_pkg.sv
package ubg_pkg;
  localparam int CODE_W       = 3;
  localparam int PSC_W        = 5;
  localparam int BUS_W        = 32;
  localparam int IDX_DIV_LO   = 0;
  localparam int IDX_LCR      = 3;
  localparam int IDX_PSC      = 10;
  localparam int IDX_XY       = 11;
  localparam int LCR_DLAB_BIT = 7;
  localparam int OVS          = 16;

  function automatic logic [PSC_W-1:0] psc_ratio(input logic [CODE_W-1:0] code);
    case (code)
      3'd0:    return PSC_W'(1);
      3'd1:    return PSC_W'(2);
      3'd2:    return PSC_W'(4);
      3'd3:    return PSC_W'(8);
      3'd4:    return PSC_W'(10);
      3'd5:    return PSC_W'(12);
      3'd6:    return PSC_W'(16);
      default: return PSC_W'(20);
    endcase
  endfunction
endpackage

// File: rtl/ubg_regs.sv
module ubg_regs
  import ubg_pkg::*;
#(
  parameter int DIV_W  = 16,
  parameter int FRAC_W = 16,
  parameter int ADDR_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [BUS_W-1:0]   wdata_i,
  output logic [BUS_W-1:0]   rdata_o,
  output logic [DIV_W-1:0]   div_o,
  output logic [CODE_W-1:0]  code_o,
  output logic [FRAC_W-1:0]  x_o,
  output logic [FRAC_W-1:0]  y_o,
  output logic               dlab_o,
  output logic               restart_o
);
  localparam int NB = DIV_W / 8;
  localparam logic [FRAC_W-1:0] Y_RST = FRAC_W'(65000);

  logic [7:0]        lcr_q;
  logic [CODE_W-1:0] code_q;
  logic [FRAC_W-1:0] x_q, y_q;
  logic [NB-1:0]     div_we;
  logic [FRAC_W-1:0] x_new, y_new;
  logic              lcr_we, psc_we, xy_we;

  assign x_new  = wdata_i[2*FRAC_W-1:FRAC_W];
  assign y_new  = wdata_i[FRAC_W-1:0];
  assign lcr_we = wr_en_i && (addr_i == ADDR_W'(IDX_LCR));
  assign psc_we = wr_en_i && (addr_i == ADDR_W'(IDX_PSC));
  assign xy_we  = wr_en_i && (addr_i == ADDR_W'(IDX_XY)) && (x_new < y_new);
  assign dlab_o = lcr_q[LCR_DLAB_BIT];

  for (genvar b = 0; b < NB; b++) begin : g_div
    logic [7:0] q;
    assign div_we[b] = wr_en_i && dlab_o && (addr_i == ADDR_W'(IDX_DIV_LO + b));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        q <= (b == 0) ? 8'd1 : 8'd0;
      else if (div_we[b]) q <= wdata_i[7:0];
    end
    assign div_o[8*b +: 8] = q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lcr_q  <= '0;
      code_q <= CODE_W'(4);
      x_q    <= '0;
      y_q    <= Y_RST;
    end else begin
      if (lcr_we) lcr_q  <= wdata_i[7:0];
      if (psc_we) code_q <= wdata_i[CODE_W-1:0];
      if (xy_we) begin
        x_q <= x_new;
        y_q <= y_new;
      end
    end
  end

  assign code_o    = code_q;
  assign x_o       = x_q;
  assign y_o       = y_q;
  assign restart_o = (|div_we) || psc_we || xy_we;

  always_comb begin
    rdata_o = '0;
    for (int b = 0; b < NB; b++)
      if (addr_i == ADDR_W'(IDX_DIV_LO + b)) rdata_o = BUS_W'(div_o[8*b +: 8]);
    if (addr_i == ADDR_W'(IDX_LCR)) rdata_o = BUS_W'(lcr_q);
    if (addr_i == ADDR_W'(IDX_PSC)) rdata_o = BUS_W'(code_q);
    if (addr_i == ADDR_W'(IDX_XY))  rdata_o = BUS_W'({x_q, y_q});
  end
endmodule

// File: rtl/ubg_prescale.sv
module ubg_prescale
  import ubg_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [PSC_W-1:0] ratio_i,
  output logic             en_o
);
  logic [PSC_W-1:0] cnt_q;

  assign en_o = (cnt_q == ratio_i - PSC_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (en_o)  cnt_q <= '0;
    else            cnt_q <= cnt_q + PSC_W'(1);
  end
endmodule

// File: rtl/ubg_frac.sv
module ubg_frac #(
  parameter int FRAC_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              en_i,
  input  logic [FRAC_W-1:0] x_i,
  input  logic [FRAC_W-1:0] y_i,
  output logic              pulse_o
);
  logic [FRAC_W-1:0] acc_q;
  logic [FRAC_W:0]   sum, over;
  logic              wrap;

  // acc < Y and X < Y, so sum < 2Y and the remainder fits FRAC_W bits
  assign sum  = {1'b0, acc_q} + {1'b0, x_i};
  assign over = sum - {1'b0, y_i};
  assign wrap = (sum >= {1'b0, y_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q   <= '0;
      pulse_o <= 1'b0;
    end else if (clr_i) begin
      acc_q   <= '0;
      pulse_o <= 1'b0;
    end else if (en_i) begin
      acc_q   <= wrap ? over[FRAC_W-1:0] : sum[FRAC_W-1:0];
      pulse_o <= wrap;
    end else begin
      pulse_o <= 1'b0;
    end
  end
endmodule

// File: rtl/ubg_divcnt.sv
module ubg_divcnt #(
  parameter int DIV_W = 16,
  parameter int OVS   = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             sample_o,
  output logic             bit_o
);
  localparam int OVS_W = $clog2(OVS);

  logic [DIV_W-1:0] dcnt_q, div_eff;
  logic [OVS_W-1:0] ocnt_q;
  logic             last, ovs_last;

  assign div_eff  = (div_i == '0) ? DIV_W'(1) : div_i;
  assign last     = en_i && (dcnt_q == div_eff - DIV_W'(1));
  assign ovs_last = (ocnt_q == OVS_W'(OVS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dcnt_q   <= '0;
      ocnt_q   <= '0;
      sample_o <= 1'b0;
      bit_o    <= 1'b0;
    end else if (clr_i) begin
      dcnt_q   <= '0;
      ocnt_q   <= '0;
      sample_o <= 1'b0;
      bit_o    <= 1'b0;
    end else begin
      sample_o <= last;
      bit_o    <= last && ovs_last;
      if (last) begin
        dcnt_q <= '0;
        ocnt_q <= ovs_last ? '0 : ocnt_q + OVS_W'(1);
      end else if (en_i) begin
        dcnt_q <= dcnt_q + DIV_W'(1);
      end
    end
  end
endmodule

// File: rtl/uart_baud_gen.sv
module uart_baud_gen
  import ubg_pkg::*;
#(
  parameter int DIV_W  = 16,
  parameter int FRAC_W = 16,
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              sample_tick_o,
  output logic              bit_tick_o
);
  logic [DIV_W-1:0]  div_w;
  logic [CODE_W-1:0] code_w;
  logic [FRAC_W-1:0] x_w, y_w;
  logic              dlab_w, restart_w, pre_en_w, frac_en_w;

  ubg_regs #(.DIV_W(DIV_W), .FRAC_W(FRAC_W), .ADDR_W(ADDR_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i, .rdata_o,
    .div_o(div_w), .code_o(code_w), .x_o(x_w), .y_o(y_w),
    .dlab_o(dlab_w), .restart_o(restart_w)
  );

  ubg_prescale u_psc (
    .clk_i, .rst_ni, .clr_i(restart_w), .ratio_i(psc_ratio(code_w)), .en_o(pre_en_w)
  );

  ubg_frac #(.FRAC_W(FRAC_W)) u_frac (
    .clk_i, .rst_ni, .clr_i(restart_w), .en_i(pre_en_w),
    .x_i(x_w), .y_i(y_w), .pulse_o(frac_en_w)
  );

  ubg_divcnt #(.DIV_W(DIV_W), .OVS(OVS)) u_div (
    .clk_i, .rst_ni, .clr_i(restart_w), .en_i(frac_en_w), .div_i(div_w),
    .sample_o(sample_tick_o), .bit_o(bit_tick_o)
  );
endmodule

// File: rtl/ubg_chk.sv
module ubg_chk
  import ubg_pkg::*;
#(
  parameter int DIV_W  = 16,
  parameter int FRAC_W = 16,
  parameter int ADDR_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [31:0]       wdata_i,
  input logic              dlab_i,
  input logic [DIV_W-1:0]  div_i,
  input logic [FRAC_W-1:0] x_i,
  input logic [FRAC_W-1:0] y_i,
  input logic              sample_i,
  input logic              bit_i
);
  AST_BIT_WITH_SAMPLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_i |-> sample_i); // R7

  AST_BIT_SPACED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_i |=> !bit_i); // R7

  AST_DLAB_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !dlab_i && addr_i < ADDR_W'(2)) |=> $stable(div_i)); // R5

  AST_XY_REJECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == ADDR_W'(IDX_XY) && wdata_i[31:16] >= wdata_i[15:0])
      |=> ($stable(x_i) && $stable(y_i))); // R4

  AST_QUIET_AFTER_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == ADDR_W'(IDX_PSC)) |=> (!sample_i && !bit_i)); // R8

  AST_Y_ABOVE_X: assert property (@(posedge clk_i) disable iff (!rst_ni)
    x_i < y_i); // R4
endmodule

bind uart_baud_gen ubg_chk #(.DIV_W(DIV_W), .FRAC_W(FRAC_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i), .wdata_i(wdata_i),
  .dlab_i(dlab_w), .div_i(div_w), .x_i(x_w), .y_i(y_w),
  .sample_i(sample_tick_o), .bit_i(bit_tick_o)
);

// File: tb/uart_baud_gen_test.sv
module uart_baud_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        sample_tick, bit_tick;
  int          n_chk = 0;
  int          n_fail = 0;

  always #2.5 clk = ~clk;

  uart_baud_gen uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .sample_tick_o(sample_tick), .bit_tick_o(bit_tick)
  );

  function automatic int ratio_of(input int code);
    case (code)
      0: return 1;  1: return 2;  2: return 4;  3: return 8;
      4: return 10; 5: return 12; 6: return 16; default: return 20;
    endcase
  endfunction

  task automatic check(input string req, input longint act, input longint exp, input string what);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    addr = 4'(a); wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_check(input string req, input int a, input logic [31:0] exp);
    @(negedge clk);
    addr = 4'(a);
    #1;
    check(req, longint'(rdata), longint'(exp), $sformatf("readback idx %0d", a));
  endtask

  task automatic cfg(input int code, input int dv, input int x, input int y);
    wr(3, 32'h83);
    wr(0, 32'(dv & 8'hFF));
    wr(1, 32'((dv >> 8) & 8'hFF));
    wr(3, 32'h03);
    wr(10, 32'(code));
    wr(11, {16'(x), 16'(y)});
  endtask

  // cycles spanned by n sample ticks, starting at a tick
  task automatic span(input int n, output longint cyc);
    int k = 0;
    cyc = 0;
    while (!sample_tick) @(negedge clk);
    while (k < n) begin
      @(negedge clk);
      cyc++;
      if (sample_tick) k++;
    end
  endtask

  task automatic t_reset;
    int seen = 0;
    rd_check("R1", 0, 32'd1);
    rd_check("R1", 1, 32'd0);
    rd_check("R1", 3, 32'd0);
    rd_check("R1", 10, 32'd4);
    rd_check("R1", 11, 32'h0000FDE8);
    rd_check("R9", 5, 32'd0);
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (sample_tick || bit_tick) seen++;
    end
    check("R1", seen, 0, "strobes after reset");
  endtask

  task automatic t_dlab;
    wr(3, 32'h03);
    wr(0, 32'd5);
    rd_check("R5", 0, 32'd1);
    wr(3, 32'h83);
    wr(0, 32'd5);
    rd_check("R5", 0, 32'd5);
    rd_check("R9", 3, 32'h83);
    wr(0, 32'd1);
    wr(3, 32'h03);
  endtask

  task automatic t_xy_reject;
    wr(11, {16'd500, 16'd500});
    rd_check("R4", 11, 32'h0000FDE8);
    wr(11, {16'd600, 16'd500});
    rd_check("R4", 11, 32'h0000FDE8);
  endtask

  task automatic t_div_zero;
    longint c;
    cfg(0, 0, 1, 2);
    span(8, c);
    check("R6", c, 16, "span of 8 ticks, divisor 0");
    cfg(0, 3, 1, 2);
    span(8, c);
    check("R3", c, 48, "span of 8 ticks, divisor 3");
  endtask

  task automatic t_prescale;
    longint c;
    for (int code = 0; code < 8; code++) begin
      cfg(code, 1, 1, 2);
      span(4, c);
      check("R2", c, 8 * ratio_of(code), $sformatf("span of 4 ticks, code %0d", code));
    end
  endtask

  task automatic t_bit;
    int cnt = 0;
    int got = 0;
    cfg(0, 1, 1, 2);
    while (got < 2) begin
      @(negedge clk);
      if (sample_tick) cnt++;
      if (bit_tick) begin
        check("R7", cnt, 16, "sample ticks per bit tick");
        check("R7", longint'(sample_tick), 1, "bit tick aligned to sample");
        cnt = 0;
        got++;
      end
    end
  endtask

  task automatic t_restart;
    int n;
    cfg(0, 3, 1, 2);
    repeat (7) @(negedge clk);
    wr(3, 32'h83);
    wr(0, 32'd1);
    n = 0;
    while (!sample_tick && n < 50) begin @(negedge clk); n++; end
    check("R8", n, 3, "edges to first tick after divisor write");
    wr(3, 32'h03);
    repeat (5) @(negedge clk);
    wr(10, 32'd0);
    n = 0;
    while (!sample_tick && n < 50) begin @(negedge clk); n++; end
    check("R8", n, 3, "edges to first tick after prescaler write");
  endtask

  task automatic t_baud(input int baud);
    int code = 0, p = 0, x = 0;
    longint c, exp, d;
    int rat[3] = '{10, 4, 2};
    int cod[3] = '{4, 2, 1};
    for (int i = 0; i < 3; i++) begin
      x = ((baud * 1625) / (500000 / rat[i])) << 4;
      code = cod[i]; p = rat[i];
      if (x < 65000) break;
    end
    cfg(code, 1, x, 65000);
    span(1000, c);
    exp = (longint'(1000) * p * 65000) / x;
    d = (c > exp) ? c - exp : exp - c;
    n_chk++;
    if (d > 2 * p + 2) begin
      n_fail++;
      $display("FAIL R3 %0d baud span: actual %0d expected %0d", baud, c, exp);
    end
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_dlab();
    t_xy_reject();
    t_div_zero();
    t_prescale();
    t_bit();
    t_restart();
    t_baud(460800);
    t_baud(115200);
    t_baud(9600);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule